// File: doc/BRIEF.md
# Dual-Issue Pairing and Issue Check

This block is the issue stage of a two-wide, in-order, statically scheduled pipeline. It keeps two decoded instructions in a pair of staging slots, older first. Each cycle it decides whether none, the older one, or both of them leave for execution. Every instruction has a class, a destination register and two source registers. The block also reads the busy vectors of the integer and floating-point scoreboards. A pair may go together only when one member runs on the integer side and the other is a floating-point operation. The pair must also be free of branches and of any same-file dependence between its two members.

The block reports the issued slots as strobes and as a count. It drives one mark vector per register file, naming the destinations that must be flagged busy for the instructions issued this cycle. It also tells the instruction supplier how many positions of its in-order stream it takes at the next clock edge (`adv_cnt`). The supplier always presents the next two not-yet-taken instructions on the input ports and moves forward by `adv_cnt` after each edge. Slots refill from those inputs. When only the older slot issues, the younger one moves into the older position.

Class codes are INT=0, LOAD=1, STORE=2, BRANCH=3, FPOP=4 and FPLOAD=5. FPOP is the only floating-point-class code. All others are integer-class, including FPLOAD. Sources name integer registers for every class except FPOP, whose sources are floating-point registers. The destination is an integer register for INT and LOAD and a floating-point register for FPOP and FPLOAD. STORE and BRANCH write no register. Both source fields are always compared, so a one-source instruction repeats its source. Slot k of each flattened input occupies bits [k*W +: W] of that input.

Top module: `dual_issue_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, the staging slots are empty. That cycle shows `issue_cnt`=0, `issue_vld`=0, both mark vectors zero and `adv_cnt`=2.
- R2: Two instructions issue in the same cycle only when exactly one of them has class FPOP (4). The order within the pair does not matter. Two integer-class or two FPOP instructions issue one per cycle.
- R3: Issue keeps program order. `issue_vld[1]` is never set without `issue_vld[0]`, so a stalled older slot stops the younger one too.
- R4: The younger slot is held when one of its sources names the older slot's destination in the same register file. It is also held when both slots write the same register of the same file. Equal register numbers in different files never hold it.
- R5: A BRANCH (3) never shares its issue cycle with another instruction, whichever slot it occupies.
- R6: A slot does not issue while one of its source registers, or its destination register, is busy in that register's scoreboard.
- R7: In the cycle an instruction issues, bit `dst` of `int_mark` (INT, LOAD) or of `fp_mark` (FPOP, FPLOAD) is set. STORE and BRANCH set no mark bit.
- R8: An FPLOAD (5) pairs as integer-class with an FPOP. Its destination lies in the floating-point file, so an FPOP in the same pair that reads it issues one cycle later.
- R9: When only the older slot issues, the younger instruction becomes the older slot at the next edge and issues from there. `adv_cnt` then equals 1.
- R10: In a cycle where both valid slots stay, `adv_cnt`=0. Both instructions are kept unchanged and issue once the stall clears.
- R11: `issue_cnt` always equals the number of set bits in `issue_vld` and is 0, 1 or 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_vld | input | 2 | Valid bits of the next two stream positions |
| in_cls | input | 6 | Class codes, 3 bits per position |
| in_dst | input | 10 | Destination registers, 5 bits per position |
| in_srca | input | 10 | First source registers |
| in_srcb | input | 10 | Second source registers |
| int_busy | input | 32 | Integer scoreboard busy bits |
| fp_busy | input | 32 | Floating-point scoreboard busy bits |
| issue_vld | output | 2 | Issue strobe per staging slot (bit 0 = older) |
| issue_cnt | output | 2 | Number of instructions issued this cycle |
| adv_cnt | output | 2 | Stream positions taken at the next edge |
| int_mark | output | 32 | Integer destinations to flag busy |
| fp_mark | output | 32 | Floating-point destinations to flag busy |

## Verification
The issue decision is combinational on the staging slots and the busy inputs. Strobes, count, marks and `adv_cnt` therefore belong to the cycle in which a pair sits in the slots. Stream inputs are captured at an edge, so an instruction offered in cycle N is first judged in cycle N+1. A younger instruction left behind by a single issue is judged again in the next cycle from the older position. The bench drives inputs and busy vectors at the falling edge and samples all outputs 1 ns later, before the next rising edge. It advances its stream pointer by the `adv_cnt` sampled in the previous cycle. Each expected value is tied to a cycle index counted from the first cycle after reset, which is cycle 0 and always empty.

// File: rtl/dual_issue_pkg.sv
`timescale 1ns/1ps
package dual_issue_pkg;

    localparam int NUM_REGS = 32;
    localparam int REG_W    = $clog2(NUM_REGS);
    localparam int CLS_W    = 3;
    localparam int LANES    = 2;

    typedef enum logic [CLS_W-1:0] {
        C_INT    = 3'd0,
        C_LOAD   = 3'd1,
        C_STORE  = 3'd2,
        C_BRANCH = 3'd3,
        C_FPOP   = 3'd4,
        C_FPLOAD = 3'd5
    } iclass_e;

    typedef struct packed {
        logic             vld;
        iclass_e          cls;
        logic [REG_W-1:0] dst;
        logic [REG_W-1:0] sa;
        logic [REG_W-1:0] sb;
    } slot_t;

    // floating-point class for pairing purposes
    function automatic logic is_fp_op(iclass_e c);
        return c == C_FPOP;
    endfunction

    function automatic logic writes_dst(iclass_e c);
        return (c == C_INT) || (c == C_LOAD) || (c == C_FPOP) || (c == C_FPLOAD);
    endfunction

    function automatic logic dst_in_fp(iclass_e c);
        return (c == C_FPOP) || (c == C_FPLOAD);
    endfunction

    function automatic logic src_in_fp(iclass_e c);
        return c == C_FPOP;
    endfunction

endpackage

// File: rtl/slot_stage.sv
`timescale 1ns/1ps
module slot_stage
    import dual_issue_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  slot_t      nxt0,
    input  slot_t      nxt1,
    input  logic [1:0] adv,
    output slot_t      q0,
    output slot_t      q1
);

    always_ff @(posedge clk) begin
        if (rst) begin
            q0 <= '0;
            q1 <= '0;
        end else begin
            case (adv)
                2'd2: begin
                    q0 <= nxt0;
                    q1 <= nxt1;
                end
                2'd1: begin
                    q0 <= q1;
                    q1 <= nxt0;
                end
                default: begin
                    q0 <= q0;
                    q1 <= q1;
                end
            endcase
        end
    end

endmodule

// File: rtl/slot_ready.sv
`timescale 1ns/1ps
module slot_ready
    import dual_issue_pkg::*;
(
    input  slot_t                s,
    input  logic [NUM_REGS-1:0]  int_busy,
    input  logic [NUM_REGS-1:0]  fp_busy,
    output logic                 ready
);

    logic src_busy;
    logic dst_busy;

    always_comb begin
        if (src_in_fp(s.cls))
            src_busy = fp_busy[s.sa] | fp_busy[s.sb];
        else
            src_busy = int_busy[s.sa] | int_busy[s.sb];

        if (!writes_dst(s.cls))
            dst_busy = 1'b0;
        else if (dst_in_fp(s.cls))
            dst_busy = fp_busy[s.dst];
        else
            dst_busy = int_busy[s.dst];

        ready = s.vld && !src_busy && !dst_busy;
    end

endmodule

// File: rtl/pair_check.sv
`timescale 1ns/1ps
module pair_check
    import dual_issue_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  slot_t      q0,
    input  slot_t      q1,
    input  logic       rdy0,
    input  logic       rdy1,
    output logic [1:0] iss
);

    logic mix_ok;
    logic no_branch;
    logic raw_hit;
    logic waw_hit;

    always_comb begin
        mix_ok    = is_fp_op(q0.cls) != is_fp_op(q1.cls);
        no_branch = (q0.cls != C_BRANCH) && (q1.cls != C_BRANCH);
        raw_hit   = writes_dst(q0.cls)
                 && (dst_in_fp(q0.cls) == src_in_fp(q1.cls))
                 && ((q1.sa == q0.dst) || (q1.sb == q0.dst));
        waw_hit   = writes_dst(q0.cls) && writes_dst(q1.cls)
                 && (dst_in_fp(q0.cls) == dst_in_fp(q1.cls))
                 && (q1.dst == q0.dst);
        iss[0]    = rdy0;
        iss[1]    = rdy0 && rdy1 && mix_ok && no_branch && !raw_hit && !waw_hit;
    end

    AST_YOUNGER_NEEDS_OLDER: assert property (@(posedge clk) disable iff (rst)
        iss[1] |-> iss[0]) else $error("younger slot issued alone"); // R3

    AST_PAIR_IS_MIXED: assert property (@(posedge clk) disable iff (rst)
        iss[1] |-> (q0.cls == C_FPOP) != (q1.cls == C_FPOP)) else $error("pair not mixed"); // R2

    AST_BRANCH_SOLO: assert property (@(posedge clk) disable iff (rst)
        iss[1] |-> (q0.cls != C_BRANCH) && (q1.cls != C_BRANCH)) else $error("branch paired"); // R5

endmodule

// File: rtl/dual_issue_ctrl.sv
`timescale 1ns/1ps
module dual_issue_ctrl
    import dual_issue_pkg::*;
(
    input  logic                      clk,
    input  logic                      rst,
    input  logic [LANES-1:0]          in_vld,
    input  logic [LANES*CLS_W-1:0]    in_cls,
    input  logic [LANES*REG_W-1:0]    in_dst,
    input  logic [LANES*REG_W-1:0]    in_srca,
    input  logic [LANES*REG_W-1:0]    in_srcb,
    input  logic [NUM_REGS-1:0]       int_busy,
    input  logic [NUM_REGS-1:0]       fp_busy,
    output logic [LANES-1:0]          issue_vld,
    output logic [1:0]                issue_cnt,
    output logic [1:0]                adv_cnt,
    output logic [NUM_REGS-1:0]       int_mark,
    output logic [NUM_REGS-1:0]       fp_mark
);

    slot_t             nxt [LANES];
    slot_t             cur [LANES];
    logic [LANES-1:0]  rdy;
    logic              vac0;
    logic              vac1;

    for (genvar k = 0; k < LANES; k++) begin : g_lane
        always_comb begin
            nxt[k].vld = in_vld[k];
            nxt[k].cls = iclass_e'(in_cls[k*CLS_W +: CLS_W]);
            nxt[k].dst = in_dst[k*REG_W +: REG_W];
            nxt[k].sa  = in_srca[k*REG_W +: REG_W];
            nxt[k].sb  = in_srcb[k*REG_W +: REG_W];
        end

        slot_ready u_rdy (
            .s        (cur[k]),
            .int_busy (int_busy),
            .fp_busy  (fp_busy),
            .ready    (rdy[k])
        );
    end

    slot_stage u_stage (
        .clk  (clk),
        .rst  (rst),
        .nxt0 (nxt[0]),
        .nxt1 (nxt[1]),
        .adv  (adv_cnt),
        .q0   (cur[0]),
        .q1   (cur[1])
    );

    pair_check u_pair (
        .clk  (clk),
        .rst  (rst),
        .q0   (cur[0]),
        .q1   (cur[1]),
        .rdy0 (rdy[0]),
        .rdy1 (rdy[1]),
        .iss  (issue_vld)
    );

    always_comb begin
        vac0      = !cur[0].vld || issue_vld[0];
        vac1      = vac0 && (!cur[1].vld || issue_vld[1]);
        adv_cnt   = {1'b0, vac0} + {1'b0, vac1};
        issue_cnt = {1'b0, issue_vld[0]} + {1'b0, issue_vld[1]};
    end

    for (genvar r = 0; r < NUM_REGS; r++) begin : g_mark
        assign int_mark[r] =
              (issue_vld[0] && writes_dst(cur[0].cls) && !dst_in_fp(cur[0].cls) && cur[0].dst == REG_W'(r))
           || (issue_vld[1] && writes_dst(cur[1].cls) && !dst_in_fp(cur[1].cls) && cur[1].dst == REG_W'(r));
        assign fp_mark[r] =
              (issue_vld[0] && dst_in_fp(cur[0].cls) && cur[0].dst == REG_W'(r))
           || (issue_vld[1] && dst_in_fp(cur[1].cls) && cur[1].dst == REG_W'(r));
    end

    AST_SHIFT_YOUNGER: assert property (@(posedge clk) disable iff (rst)
        (issue_vld == 2'b01 && cur[1].vld) |=> cur[0] == $past(cur[1])) else $error("younger not moved up"); // R9

    AST_HOLD_BOTH: assert property (@(posedge clk) disable iff (rst)
        (issue_vld == 2'b00 && cur[0].vld && cur[1].vld) |=> (cur[0] == $past(cur[0]) && cur[1] == $past(cur[1])))
        else $error("stalled slots changed"); // R10

    AST_INT_SRC_FREE: assert property (@(posedge clk) disable iff (rst)
        (issue_vld[0] && cur[0].cls != C_FPOP) |-> !int_busy[cur[0].sa] && !int_busy[cur[0].sb])
        else $error("issued over busy source"); // R6

    AST_MARK_BOUND: assert property (@(posedge clk) disable iff (rst)
        ($countones(int_mark) + $countones(fp_mark)) <= int'(issue_cnt)) else $error("too many marks"); // R7

endmodule

// File: tb/tb_dual_issue_ctrl.sv
`timescale 1ns/1ps
module tb_dual_issue_ctrl;

    localparam int K_INT = 0, K_LOAD = 1, K_STORE = 2, K_BR = 3, K_FPOP = 4, K_FPLD = 5;
    localparam int MAXP = 16;

    logic        clk = 1'b0;
    logic        rst;
    logic [1:0]  in_vld;
    logic [5:0]  in_cls;
    logic [9:0]  in_dst, in_srca, in_srcb;
    logic [31:0] int_busy, fp_busy;
    logic [1:0]  issue_vld, issue_cnt, adv_cnt;
    logic [31:0] int_mark, fp_mark;

    always #4 clk = ~clk;

    dual_issue_ctrl dut (
        .clk(clk), .rst(rst), .in_vld(in_vld), .in_cls(in_cls), .in_dst(in_dst),
        .in_srca(in_srca), .in_srcb(in_srcb), .int_busy(int_busy), .fp_busy(fp_busy),
        .issue_vld(issue_vld), .issue_cnt(issue_cnt), .adv_cnt(adv_cnt),
        .int_mark(int_mark), .fp_mark(fp_mark)
    );

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    int p_cls [MAXP], p_dst [MAXP], p_sa [MAXP], p_sb [MAXP];
    int plen, ptr, last_adv, clr_at;
    logic [31:0] cfg_ib, cfg_fb;

    int          r_cnt [MAXP];
    int          r_adv [MAXP];
    logic [1:0]  r_vec [MAXP];
    logic [31:0] r_im  [MAXP];
    logic [31:0] r_fm  [MAXP];

    task automatic chk(string req, int got, int exp);
        n_chk++;
        if (got != exp) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, exp);
        end
    endtask

    task automatic clear_prog();
        plen = 0; cfg_ib = '0; cfg_fb = '0; clr_at = MAXP;
    endtask

    task automatic add_i(int c, int d, int a, int b);
        p_cls[plen] = c; p_dst[plen] = d; p_sa[plen] = a; p_sb[plen] = b;
        plen++;
    endtask

    task automatic drive_stream();
        for (int k = 0; k < 2; k++) begin
            int idx = ptr + k;
            if (idx < plen) begin
                in_vld[k]         = 1'b1;
                in_cls[k*3 +: 3]  = 3'(p_cls[idx]);
                in_dst[k*5 +: 5]  = 5'(p_dst[idx]);
                in_srca[k*5 +: 5] = 5'(p_sa[idx]);
                in_srcb[k*5 +: 5] = 5'(p_sb[idx]);
            end else begin
                in_vld[k]         = 1'b0;
                in_cls[k*3 +: 3]  = '0;
                in_dst[k*5 +: 5]  = '0;
                in_srca[k*5 +: 5] = '0;
                in_srcb[k*5 +: 5] = '0;
            end
        end
    endtask

    // reset, then run ncyc cycles from cycle 0 (first cycle after reset)
    task automatic run(int ncyc);
        @(negedge clk);
        rst = 1'b1; ptr = 0; last_adv = 0;
        int_busy = '0; fp_busy = '0; drive_stream();
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int c = 0; c < ncyc; c++) begin
            if (c > 0) ptr += last_adv;
            int_busy = (c >= clr_at) ? '0 : cfg_ib;
            fp_busy  = (c >= clr_at) ? '0 : cfg_fb;
            drive_stream();
            #1;
            r_cnt[c] = int'(issue_cnt); r_vec[c] = issue_vld; r_adv[c] = int'(adv_cnt);
            r_im[c]  = int_mark;        r_fm[c]  = fp_mark;
            last_adv = int'(adv_cnt);
            chk("R11 count vs strobes", int'(issue_cnt), $countones(issue_vld));
            @(negedge clk);
        end
    endtask

    task automatic t_pair_basic();
        clear_prog();
        add_i(K_INT, 1, 2, 3);
        add_i(K_FPOP, 1, 2, 3);
        run(3);
        chk("R1 empty cycle count", r_cnt[0], 0);
        chk("R1 empty cycle strobes", int'(r_vec[0]), 0);
        chk("R1 empty cycle marks", int'(r_im[0] | r_fm[0]), 0);
        chk("R1 empty cycle adv", r_adv[0], 2);
        chk("R2 int+fp pair issues", r_cnt[1], 2);
        chk("R2 pair strobes", int'(r_vec[1]), 3);
        chk("R7 int mark r1", int'(r_im[1]), 32'h2);
        chk("R7 fp mark f1", int'(r_fm[1]), 32'h2);
        chk("R2 nothing after pair", r_cnt[2], 0);
    endtask

    task automatic t_same_class();
        clear_prog();
        add_i(K_INT, 1, 2, 3);
        add_i(K_INT, 4, 5, 6);
        add_i(K_FPOP, 1, 2, 3);
        run(4);
        chk("R2 int+int single", r_cnt[1], 1);
        chk("R9 adv after single", r_adv[1], 1);
        chk("R9 moved int pairs with fp", r_cnt[2], 2);
        clear_prog();
        add_i(K_FPOP, 1, 2, 3);
        add_i(K_FPOP, 4, 5, 6);
        run(4);
        chk("R2 fp+fp single", r_cnt[1], 1);
        chk("R3 older strobe only", int'(r_vec[1]), 1);
        chk("R9 second fp next cycle", r_cnt[2], 1);
    endtask

    task automatic t_dependence();
        clear_prog();
        add_i(K_FPLD, 7, 1, 1);
        add_i(K_FPOP, 8, 7, 2);
        run(3);
        chk("R8 dependent fp op held", r_cnt[1], 1);
        chk("R8 fp load marks fp file", int'(r_fm[1]), 32'h80);
        chk("R8 fp load no int mark", int'(r_im[1]), 0);
        chk("R4 held op issues next", r_cnt[2], 1);
        clear_prog();
        add_i(K_FPLD, 7, 1, 1);
        add_i(K_FPOP, 9, 2, 3);
        run(2);
        chk("R8 independent fp load pairs", r_cnt[1], 2);
        clear_prog();
        add_i(K_INT, 5, 1, 2);
        add_i(K_FPOP, 1, 5, 6);
        run(2);
        chk("R4 int dst vs fp src differ", r_cnt[1], 2);
        clear_prog();
        add_i(K_FPOP, 3, 1, 2);
        add_i(K_LOAD, 4, 3, 3);
        run(2);
        chk("R4 fp dst vs int src differ", r_cnt[1], 2);
        clear_prog();
        add_i(K_FPOP, 3, 1, 2);
        add_i(K_FPLD, 3, 9, 9);
        run(2);
        chk("R4 same fp dst held", r_cnt[1], 1);
    endtask

    task automatic t_branch_store();
        clear_prog();
        add_i(K_BR, 0, 1, 2);
        add_i(K_FPOP, 1, 2, 3);
        run(3);
        chk("R5 branch older alone", r_cnt[1], 1);
        chk("R5 fp after branch", r_cnt[2], 1);
        clear_prog();
        add_i(K_FPOP, 1, 2, 3);
        add_i(K_BR, 0, 1, 2);
        run(3);
        chk("R5 branch younger held", r_cnt[1], 1);
        chk("R5 branch issues next", r_cnt[2], 1);
        clear_prog();
        add_i(K_STORE, 9, 1, 2);
        add_i(K_FPOP, 6, 1, 2);
        run(2);
        chk("R2 store pairs with fp", r_cnt[1], 2);
        chk("R7 store no int mark", int'(r_im[1]), 0);
        chk("R7 fp mark f6", int'(r_fm[1]), 32'h40);
    endtask

    task automatic t_busy();
        clear_prog();
        add_i(K_INT, 1, 2, 3);
        add_i(K_FPOP, 1, 2, 3);
        cfg_ib = 32'h4; clr_at = 3;
        run(5);
        chk("R6 busy int source stalls", r_cnt[1], 0);
        chk("R10 stall adv zero", r_adv[2], 0);
        chk("R10 still stalled", r_cnt[2], 0);
        chk("R10 held pair issues", r_cnt[3], 2);
        clear_prog();
        add_i(K_INT, 1, 2, 3);
        add_i(K_FPOP, 1, 2, 3);
        cfg_fb = 32'h2; clr_at = 3;
        run(5);
        chk("R6 busy fp dst blocks younger", int'(r_vec[1]), 1);
        chk("R6 moved fp still busy", r_cnt[2], 0);
        chk("R9 moved fp issues", int'(r_vec[3]), 1);
        clear_prog();
        add_i(K_INT, 1, 2, 3);
        add_i(K_FPOP, 1, 2, 3);
        cfg_ib = 32'h2; clr_at = 2;
        run(4);
        chk("R3 stalled older blocks younger", r_cnt[1], 0);
        chk("R3 pair after release", r_cnt[2], 2);
    endtask

    initial begin
        rst = 1'b1; in_vld = '0; in_cls = '0; in_dst = '0; in_srca = '0; in_srcb = '0;
        int_busy = '0; fp_busy = '0;
        t_pair_basic();
        t_same_class();
        t_dependence();
        t_branch_store();
        t_busy();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule